// File: doc/BRIEF.md
# Video Test Pattern Generator

This block produces a continuous raster of 10-bit video words for a serial digital video transmitter. Chroma and luma are carried in a single interleaved stream in the order Cb, Y, Cr, Y. Each line starts with an end-of-active-video timing code. Horizontal blanking follows, then a start-of-active-video timing code, then the active samples. All of the raster geometry comes from internal word and line counters.

The active picture holds one of two patterns. The first is eight equal-width colour bars at full or reduced amplitude. The second is a two-level pathological stress field whose long constant runs load the clock-recovery loop and cable equaliser of the receiving equipment. A format input picks the standard-definition, high-definition or 3G raster size. Format, pattern and amplitude are sampled only at frame boundaries, so a frame is never torn.

Top module: `vtpg_top`

## Requirements
- R1: While `rst` is high, `word_o` reads 0x040 from the next clock edge onward. The configuration on the inputs during reset is captured. The first word after release is word 0 of line 0 of a frame in that configuration.
- R2: Every line begins with the four words 3FF, 000, 000, XYZ. Blanking words follow, then 3FF, 000, 000, XYZ. The active words close the line. Each line is the format's blanking count plus active count words long, and each frame is the format's total line count.
- R3: The XYZ word is built as bit9=1, bit8=F=0, bit7=V, bit6=H, bit5=V^H, bit4=F^H, bit3=F^V, bit2=F^V^H, bits1:0=0. H is 1 in the line-opening code and 0 in the code before the active words. V is 1 on every line at or after the format's active line count.
- R4: Every blanking word outputs 0x200 at an even word index in the line and 0x040 at an odd index. Blanking words are the horizontal blanking words and all active-position words on vertical-blanking lines.
- R5: Active words repeat Cb, Y, Cr, Y, starting with Cb at the first active word.
- R6: In bar mode the active width is divided into eight equal bars, in this order: white, yellow, cyan, green, magenta, red, blue, black.
- R7: At full amplitude (`full_amp`=1), the bar values are:
  - Y: 3AC, 348, 2A8, 244, 1A8, 144, 0A4, 040
  - Cb: 200, 040, 298, 0D8, 328, 168, 3C0, 200
  - Cr: 200, 248, 040, 088, 378, 3C0, 1B8, 200
- R8: At reduced amplitude (`full_amp`=0), the bar values are:
  - Y: 2D0, 288, 20C, 1C0, 150, 104, 08C, 040
  - Cb: 200, 0B0, 270, 120, 2E0, 190, 350, 200
  - Cr: 200, 238, 0B0, 0E8, 318, 350, 1C8, 200
- R9: In stress mode (`pat_sel`=1), the upper half of the active lines (line < active lines/2) carries chroma 0x300 and luma 0x198. The lower half carries chroma 0x200 and luma 0x110.
- R10: `fmt_sel` selects the raster: 00 is standard definition, 01 is high definition, 10 is 3G and 11 is standard definition.
- R11: Changes to `fmt_sel`, `pat_sel` or `full_amp` in mid-frame leave the current frame untouched. They take effect from word 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Raster format select |
| pat_sel | input | 1 | 0 selects colour bars, 1 selects the stress field |
| full_amp | input | 1 | 1 selects full bar amplitude, 0 selects reduced amplitude |
| word_o | output | 10 | Interleaved video word, registered |

## Verification
A word counter that slips shows up at the port within one line, as a timing code out of place or a wrong blanking parity. A bar counter that slips shows up within one bar width, as the next colour arriving early or late. A wrong V flag or line count appears in the XYZ word of the next line. A configuration register that loads outside the frame boundary shows up in the same frame, as a wrong line length or a wrong colour value.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

    typedef enum logic [1:0] {
        FMT_SD  = 2'b00,
        FMT_HD  = 2'b01,
        FMT_3G  = 2'b10,
        FMT_ALT = 2'b11
    } fmt_e;

    typedef enum logic {
        PAT_BARS   = 1'b0,
        PAT_STRESS = 1'b1
    } pat_e;

    typedef struct packed {
        fmt_e fmt;
        pat_e pat;
        logic full_amp;
    } cfg_t;

    typedef enum logic [1:0] {
        REG_EAV,
        REG_HBLK,
        REG_SAV,
        REG_ACT
    } region_e;

    typedef struct packed {
        logic [9:0] y;
        logic [9:0] cb;
        logic [9:0] cr;
    } ycc_t;

    localparam logic [9:0] BLANK_C   = 10'h200;
    localparam logic [9:0] BLANK_Y   = 10'h040;
    localparam logic [9:0] CODE_HI   = 10'h3FF;
    localparam logic [9:0] CODE_LO   = 10'h000;
    localparam logic [9:0] STRESS_C0 = 10'h300;
    localparam logic [9:0] STRESS_Y0 = 10'h198;
    localparam logic [9:0] STRESS_C1 = 10'h200;
    localparam logic [9:0] STRESS_Y1 = 10'h110;

    // Protected flag word of a timing code
    function automatic logic [9:0] xyz(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    // Bar colour lookup, idx 0 = white ... 7 = black
    function automatic ycc_t bar_colour(input logic [2:0] idx, input logic full);
        ycc_t c;
        case ({full, idx})
            4'b1_000: c = '{10'h3AC, 10'h200, 10'h200};
            4'b1_001: c = '{10'h348, 10'h040, 10'h248};
            4'b1_010: c = '{10'h2A8, 10'h298, 10'h040};
            4'b1_011: c = '{10'h244, 10'h0D8, 10'h088};
            4'b1_100: c = '{10'h1A8, 10'h328, 10'h378};
            4'b1_101: c = '{10'h144, 10'h168, 10'h3C0};
            4'b1_110: c = '{10'h0A4, 10'h3C0, 10'h1B8};
            4'b0_000: c = '{10'h2D0, 10'h200, 10'h200};
            4'b0_001: c = '{10'h288, 10'h0B0, 10'h238};
            4'b0_010: c = '{10'h20C, 10'h270, 10'h0B0};
            4'b0_011: c = '{10'h1C0, 10'h120, 10'h0E8};
            4'b0_100: c = '{10'h150, 10'h2E0, 10'h318};
            4'b0_101: c = '{10'h104, 10'h190, 10'h350};
            4'b0_110: c = '{10'h08C, 10'h350, 10'h1C8};
            default:  c = '{BLANK_Y, BLANK_C, BLANK_C};
        endcase
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vtpg_raster.sv
module vtpg_raster
    import vtpg_pkg::*;
#(
    parameter int SD_ACT_WORDS = 1440,
    parameter int SD_BLK_WORDS = 276,
    parameter int SD_ACT_LINES = 486,
    parameter int SD_TOT_LINES = 525,
    parameter int HD_ACT_WORDS = 2560,
    parameter int HD_BLK_WORDS = 740,
    parameter int HD_ACT_LINES = 720,
    parameter int HD_TOT_LINES = 750,
    parameter int TG_ACT_WORDS = 3840,
    parameter int TG_BLK_WORDS = 560,
    parameter int TG_ACT_LINES = 1080,
    parameter int TG_TOT_LINES = 1125,
    parameter int HW = 13,
    parameter int VW = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_t        cfg_in,
    output cfg_t        cfg_q,
    output region_e     region,
    output logic [1:0]  phase,
    output logic [2:0]  bar,
    output logic        vblank,
    output logic        upper,
    output logic        frame_end
);

    logic [HW-1:0] hc, bw;
    logic [VW-1:0] vc;
    logic [HW-1:0] act_w, blk_w, bar_w;
    logic [VW-1:0] act_l, tot_l;
    logic          line_end;

    // Geometry of the latched format
    always_comb begin
        case (cfg_q.fmt)
            FMT_HD: begin
                act_w = HW'(HD_ACT_WORDS); blk_w = HW'(HD_BLK_WORDS);
                act_l = VW'(HD_ACT_LINES); tot_l = VW'(HD_TOT_LINES);
            end
            FMT_3G: begin
                act_w = HW'(TG_ACT_WORDS); blk_w = HW'(TG_BLK_WORDS);
                act_l = VW'(TG_ACT_LINES); tot_l = VW'(TG_TOT_LINES);
            end
            default: begin
                act_w = HW'(SD_ACT_WORDS); blk_w = HW'(SD_BLK_WORDS);
                act_l = VW'(SD_ACT_LINES); tot_l = VW'(SD_TOT_LINES);
            end
        endcase
        bar_w = act_w >> 3;
    end

    always_comb begin
        line_end  = (hc == act_w + blk_w - HW'(1));
        frame_end = line_end && (vc == tot_l - VW'(1));
        if (hc < HW'(4))              region = REG_EAV;
        else if (hc < blk_w - HW'(4)) region = REG_HBLK;
        else if (hc < blk_w)          region = REG_SAV;
        else                          region = REG_ACT;
        phase  = hc[1:0];
        vblank = (vc >= act_l);
        upper  = (vc < (act_l >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hc    <= '0;
            vc    <= '0;
            bw    <= '0;
            bar   <= '0;
            cfg_q <= cfg_in;
        end else begin
            if (line_end) begin
                hc <= '0;
                vc <= frame_end ? '0 : vc + VW'(1);
            end else begin
                hc <= hc + HW'(1);
            end
            if (frame_end)
                cfg_q <= cfg_in;
            // bar tracking: cleared on the last code word, stepped through active words
            if (hc == blk_w - HW'(1)) begin
                bw  <= '0;
                bar <= '0;
            end else if (region == REG_ACT) begin
                if (bw == bar_w - HW'(1)) begin
                    bw  <= '0;
                    bar <= bar + 3'd1;
                end else begin
                    bw <= bw + HW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vtpg_pixel.sv
module vtpg_pixel
    import vtpg_pkg::*;
(
    input  cfg_t        cfg,
    input  region_e     region,
    input  logic [1:0]  phase,
    input  logic [2:0]  bar,
    input  logic        vblank,
    input  logic        upper,
    output logic [9:0]  word
);

    ycc_t colour;

    always_comb begin
        colour = bar_colour(bar, cfg.full_amp);
        word   = BLANK_Y;
        case (region)
            REG_EAV, REG_SAV: begin
                case (phase)
                    2'd0:    word = CODE_HI;
                    2'd3:    word = xyz(1'b0, vblank, region == REG_EAV);
                    default: word = CODE_LO;
                endcase
            end
            REG_HBLK: word = phase[0] ? BLANK_Y : BLANK_C;
            default: begin
                if (vblank)
                    word = phase[0] ? BLANK_Y : BLANK_C;
                else if (cfg.pat == PAT_STRESS)
                    word = phase[0] ? (upper ? STRESS_Y0 : STRESS_Y1)
                                    : (upper ? STRESS_C0 : STRESS_C1);
                else begin
                    case (phase)
                        2'd0:    word = colour.cb;
                        2'd2:    word = colour.cr;
                        default: word = colour.y;
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
    import vtpg_pkg::*;
#(
    parameter int SD_ACT_WORDS = 1440,
    parameter int SD_BLK_WORDS = 276,
    parameter int SD_ACT_LINES = 486,
    parameter int SD_TOT_LINES = 525,
    parameter int HD_ACT_WORDS = 2560,
    parameter int HD_BLK_WORDS = 740,
    parameter int HD_ACT_LINES = 720,
    parameter int HD_TOT_LINES = 750,
    parameter int TG_ACT_WORDS = 3840,
    parameter int TG_BLK_WORDS = 560,
    parameter int TG_ACT_LINES = 1080,
    parameter int TG_TOT_LINES = 1125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fmt_sel,
    input  logic       pat_sel,
    input  logic       full_amp,
    output logic [9:0] word_o
);

    localparam int MAX_WORDS = max3(SD_ACT_WORDS + SD_BLK_WORDS,
                                    HD_ACT_WORDS + HD_BLK_WORDS,
                                    TG_ACT_WORDS + TG_BLK_WORDS);
    localparam int MAX_LINES = max3(SD_TOT_LINES, HD_TOT_LINES, TG_TOT_LINES);
    localparam int HW = $clog2(MAX_WORDS);
    localparam int VW = $clog2(MAX_LINES);

    cfg_t       cfg_in, cfg_q;
    region_e    region;
    logic [1:0] phase;
    logic [2:0] bar;
    logic       vblank, upper, frame_end;
    logic [9:0] word_nxt;

    always_comb begin
        cfg_in.fmt      = fmt_e'(fmt_sel);
        cfg_in.pat      = pat_e'(pat_sel);
        cfg_in.full_amp = full_amp;
    end

    vtpg_raster #(
        .SD_ACT_WORDS(SD_ACT_WORDS), .SD_BLK_WORDS(SD_BLK_WORDS),
        .SD_ACT_LINES(SD_ACT_LINES), .SD_TOT_LINES(SD_TOT_LINES),
        .HD_ACT_WORDS(HD_ACT_WORDS), .HD_BLK_WORDS(HD_BLK_WORDS),
        .HD_ACT_LINES(HD_ACT_LINES), .HD_TOT_LINES(HD_TOT_LINES),
        .TG_ACT_WORDS(TG_ACT_WORDS), .TG_BLK_WORDS(TG_BLK_WORDS),
        .TG_ACT_LINES(TG_ACT_LINES), .TG_TOT_LINES(TG_TOT_LINES),
        .HW(HW), .VW(VW)
    ) u_raster (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_q(cfg_q),
        .region(region), .phase(phase), .bar(bar),
        .vblank(vblank), .upper(upper), .frame_end(frame_end)
    );

    vtpg_pixel u_pixel (
        .cfg(cfg_q), .region(region), .phase(phase), .bar(bar),
        .vblank(vblank), .upper(upper), .word(word_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) word_o <= BLANK_Y;
        else     word_o <= word_nxt;
    end

endmodule

// File: rtl/vtpg_chk.sv
module vtpg_chk
    import vtpg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [9:0] word,
    input cfg_t       cfg,
    input logic       frame_end
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> word == 10'h040); // R1

    AST_CODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        word == 10'h3FF |=> word == 10'h000); // R2

    AST_ZERO_IN_CODE: assert property (@(posedge clk) disable iff (rst)
        word == 10'h000 |-> ($past(word) == 10'h3FF || $past(word, 2) == 10'h3FF)); // R2

    AST_XYZ_PROTECT: assert property (@(posedge clk) disable iff (rst)
        ($past(word, 3) == 10'h3FF && $past(word, 2) == 10'h000 && $past(word) == 10'h000)
        |-> (word[9] && word[1:0] == 2'b00 && word[5] == (word[7] ^ word[6])
             && word[4] == (word[8] ^ word[6]) && word[3] == (word[8] ^ word[7])
             && word[2] == (word[8] ^ word[7] ^ word[6]))); // R3

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_end)) |-> $stable(cfg)); // R11

endmodule

bind vtpg_top vtpg_chk u_chk (
    .clk(clk), .rst(rst), .word(word_o), .cfg(cfg_q), .frame_end(frame_end)
);

// File: tb/sim_vtpg_top.sv
`timescale 1ns/1ps
module sim_vtpg_top;

    localparam int SA = 64,  SB = 16, SL = 6, ST = 8;
    localparam int HA = 96,  HB = 24, HL = 4, HT = 6;
    localparam int GA = 128, GB = 20, GL = 8, GT = 10;
    localparam int NF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] fmt = 2'b00;
    logic       pat = 1'b0;
    logic       amp = 1'b1;
    logic [9:0] word;
    logic       armed = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [9:0] w;
        string      tag;
    } item_t;
    item_t q[$];

    // Frame plan: format, pattern, amplitude
    int pf[NF] = '{0, 0, 1, 2, 0, 1, 3, 2};
    int pp[NF] = '{0, 0, 0, 1, 1, 0, 0, 0};
    int pa[NF] = '{1, 0, 1, 1, 1, 0, 1, 0};

    // Bar values from R7 (index 1) and R8 (index 0)
    logic [9:0] ty [2][8] = '{'{10'h2D0, 10'h288, 10'h20C, 10'h1C0, 10'h150, 10'h104, 10'h08C, 10'h040},
                              '{10'h3AC, 10'h348, 10'h2A8, 10'h244, 10'h1A8, 10'h144, 10'h0A4, 10'h040}};
    logic [9:0] tb [2][8] = '{'{10'h200, 10'h0B0, 10'h270, 10'h120, 10'h2E0, 10'h190, 10'h350, 10'h200},
                              '{10'h200, 10'h040, 10'h298, 10'h0D8, 10'h328, 10'h168, 10'h3C0, 10'h200}};
    logic [9:0] tr [2][8] = '{'{10'h200, 10'h238, 10'h0B0, 10'h0E8, 10'h318, 10'h350, 10'h1C8, 10'h200},
                              '{10'h200, 10'h248, 10'h040, 10'h088, 10'h378, 10'h3C0, 10'h1B8, 10'h200}};

    always #2.5 clk = ~clk;

    vtpg_top #(
        .SD_ACT_WORDS(SA), .SD_BLK_WORDS(SB), .SD_ACT_LINES(SL), .SD_TOT_LINES(ST),
        .HD_ACT_WORDS(HA), .HD_BLK_WORDS(HB), .HD_ACT_LINES(HL), .HD_TOT_LINES(HT),
        .TG_ACT_WORDS(GA), .TG_BLK_WORDS(GB), .TG_ACT_LINES(GL), .TG_TOT_LINES(GT)
    ) u0 (
        .clk(clk), .rst(rst), .fmt_sel(fmt), .pat_sel(pat), .full_amp(amp), .word_o(word)
    );

    function automatic int frame_len(input int f);
        case (f)
            1:       return (HA + HB) * HT;
            2:       return (GA + GB) * GT;
            default: return (SA + SB) * ST;   // 00 and 11 (R10)
        endcase
    endfunction

    function automatic int line_len(input int f);
        case (f)
            1:       return HA + HB;
            2:       return GA + GB;
            default: return SA + SB;
        endcase
    endfunction

    function automatic logic [9:0] ref_word(input int f, input int p, input int a,
                                            input int hc, input int vc, output string tag);
        int act, blk, al, aw, ph, b;
        logic v, h;
        logic [9:0] w;
        case (f)
            1:       begin act = HA; blk = HB; al = HL; end
            2:       begin act = GA; blk = GB; al = GL; end
            default: begin act = SA; blk = SB; al = SL; end
        endcase
        v = (vc >= al);
        if (hc < 4 || (hc >= blk - 4 && hc < blk)) begin
            h = (hc < 4);
            case (hc % 4)
                0:       w = 10'h3FF;
                3:       w = {1'b1, 1'b0, v, h, v ^ h, h, v, v ^ h, 2'b00};   // R3
                default: w = 10'h000;
            endcase
            tag = (hc % 4 == 3) ? "R3" : "R2";
        end else if (hc < blk || v) begin
            w   = (hc % 2 == 1) ? 10'h040 : 10'h200;
            tag = "R4";
        end else begin
            aw = hc - blk;
            ph = aw % 4;
            if (p == 1) begin
                if (vc < al / 2) w = (ph % 2 == 1) ? 10'h198 : 10'h300;
                else             w = (ph % 2 == 1) ? 10'h110 : 10'h200;
                tag = "R9";
            end else begin
                b = aw / (act / 8);                 // R6 equal bars
                case (ph)                           // R5 order Cb Y Cr Y
                    0:       w = tb[a][b];
                    2:       w = tr[a][b];
                    default: w = ty[a][b];
                endcase
                tag = (a == 1) ? "R5 R6 R7" : "R5 R6 R8";
            end
        end
        return w;
    endfunction

    task automatic push_frame(input int k);
        item_t it;
        string t;
        int f;
        f = pf[k];
        for (int vc = 0; vc < frame_len(f) / line_len(f); vc++) begin
            for (int hc = 0; hc < line_len(f); hc++) begin
                it.w = ref_word(f, pp[k], pa[k], hc, vc, t);
                if (k == 0 && vc == 0 && hc == 0) t = {t, " R1"};
                if (f != 0) t = {t, " R10"};
                if (k > 0) t = {t, " R11"};
                it.tag = t;
                q.push_back(it);
            end
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) armed <= !rst;

    // Monitor: pop and compare one expected word per clock
    always @(negedge clk) begin
        item_t e;
        if (armed && q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (word !== e.w) begin
                errors++;
                $display("FAIL %s word=%h expected=%h", e.tag, word, e.w);
            end
        end
    end

    // Driver
    initial begin
        fmt = 2'(pf[0]); pat = pp[0][0]; amp = pa[0][0];
        repeat (4) @(negedge clk);
        checks++;
        if (word !== 10'h040) begin   // R1 reset value
            errors++;
            $display("FAIL R1 reset word=%h expected=%h", word, 10'h040);
        end
        push_frame(0);
        rst = 1'b0;
        for (int k = 0; k < NF; k++) begin
            repeat (frame_len(pf[k]) / 2) @(negedge clk);
            if (k + 1 < NF) begin
                fmt = 2'(pf[k + 1]); pat = pp[k + 1][0]; amp = pa[k + 1][0];   // R11 mid-frame change
                push_frame(k + 1);
            end
            repeat (frame_len(pf[k]) - frame_len(pf[k]) / 2) @(negedge clk);
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired word=%h expected=end of run", word);
        finish_run();
    end

endmodule